// File: doc/BRIEF.md
# Interrupt Presentation Unit

This block is the per-processor end of a priority-based interrupt fabric. It keeps exactly one pending interrupt, described by a source number and a priority, and drives one interrupt line to its processor. Lower priority values are more urgent, and the all-ones value means "none". Software works on the unit through four operations: an accept read, a write of the processor's current priority, a write of the inter-processor-interrupt (IPI) request priority, and end-of-interrupt (EOI). Source controllers offer interrupts with a valid pulse carrying a number and a priority. The unit answers every offer in the same cycle. It either takes the offer or bounces it back.

When a pending source interrupt is displaced or dropped, the unit returns it to the source controller with a one-cycle reject pulse. It asks the sources to resend after the processor priority becomes less urgent and after every EOI. EOIs for real sources are forwarded as a one-cycle pulse carrying the source number. The IPI is built in. It uses the fixed source number 2, takes its priority from the software-written IPI priority register, and is never forwarded as an EOI.

At most one software operation is performed per cycle, chosen in the order accept, EOI, priority write, IPI priority write. Any other software requests in that cycle are discarded.

Top module: `irq_presenter`

## Requirements
- R1: After reset the interrupt line is low, the state word reads 0 (priority 0, nothing pending), the pending priority and the IPI priority are 0xFF, and no reject, resend or EOI pulse is issued.
- R2: The 32-bit state word `stateWord` carries the processor priority in bits 31:24 and the pending source number in bits 23:0. A number of zero means nothing is pending, and `irqOut` is high exactly when the number is non-zero.
- R3: An offer is bounced (`offerBounce` high in the same cycle) when its priority is greater than or equal to the processor priority, or when something is pending with a priority less than or equal to the offered one.
- R4: A taken offer replaces the pending number and priority and raises `irqOut` in the next cycle. If it displaces a source-owned interrupt, that interrupt's number is rejected in the next cycle. A displaced IPI is not rejected.
- R5: An accept read sees the old state word on `stateWord` in the same cycle. In the next cycle `irqOut` is low, the processor priority equals the former pending priority, the number is zero and the pending priority is 0xFF.
- R6: A priority write with a value below the current processor priority drops the pending interrupt when the new value is less than or equal to the pending priority. The drop clears the number, lowers `irqOut` and rejects a source-owned number.
- R7: A priority write with a value greater than or equal to the current one issues a resend pulse. It also raises the IPI if the IPI priority is below the new processor priority and the IPI-raise rule of R8 allows it.
- R8: An IPI-priority write stores the value and raises the IPI when the value is below the processor priority, unless something is pending at a priority less than or equal to it. Raising the IPI rejects a source-owned pending number, sets the number to 2, copies the IPI priority as the pending priority, and raises `irqOut`.
- R9: An EOI loads the processor priority from bits 31:24 of the written word. It forwards bits 23:0 as an EOI pulse unless they are 0 or 2, issues a resend pulse, and applies the IPI-raise check against the new priority.
- R10: An offer arriving in a cycle with any software operation is bounced and changes nothing.
- R11: Reject, resend and EOI pulses last one cycle and appear in the cycle after the operation that caused them. A reject always carries a non-zero number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offerValid | input | 1 | Source offers an interrupt this cycle |
| offerNum | input | 24 | Offered source number |
| offerPrio | input | 8 | Offered priority |
| offerBounce | output | 1 | Offer refused this cycle |
| acceptRd | input | 1 | Accept read |
| stateWord | output | 32 | Current priority and pending number (value read by accept) |
| cpprWr | input | 1 | Processor priority write |
| cpprData | input | 8 | New processor priority |
| mfrrWr | input | 1 | IPI priority write |
| mfrrData | input | 8 | New IPI priority |
| eoiWr | input | 1 | End-of-interrupt write |
| eoiData | input | 32 | Restored priority (31:24) and finished number (23:0) |
| irqOut | output | 1 | Interrupt line to the processor |
| rejectValid | output | 1 | Reject pulse to source controller |
| rejectNum | output | 24 | Rejected number |
| resendReq | output | 1 | Resend request pulse |
| eoiValid | output | 1 | EOI pulse to source controller |
| eoiNum | output | 24 | Number whose service finished |

## Verification
A wrong priority, number or owner bit inside the unit shows up at the ports within one or two operations. A corrupted pending priority makes the next offer or IPI check bounce or take the wrong way, and that is visible on `offerBounce` in the same cycle. A corrupted owner bit shows up as a missing or spurious reject pulse one cycle after a displacement or drop. A corrupted processor priority or number is visible at once on `stateWord`. The bench therefore compares every output in every cycle against an independent model. Random operations are drawn from a narrow band of priorities, so that equal-priority boundaries occur often.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

  // Strobes from the decision logic to the register datapath.
  typedef struct packed {
    logic accept;       // accept read performed
    logic cpprLoad;     // processor priority is written
    logic cpprFromEoi;  // new priority taken from EOI word
    logic drop;         // pending interrupt discarded
    logic mfrrLoad;     // IPI priority register written
    logic takeIpi;      // IPI becomes pending
    logic takeOffer;    // offered source becomes pending
    logic rejectCur;    // currently pending number returned to owner
    logic fwdEoi;       // EOI forwarded to sources
    logic resend;       // resend request to sources
  } pres_ctrl_t;

endpackage

// File: rtl/irq_presenter_ctrl.sv
module irq_presenter_ctrl
  import irq_presenter_pkg::*;
#(
  parameter int NUM_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              offerValid,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic              acceptRd,
  input  logic              cpprWr,
  input  logic [PRIO_W-1:0] cpprData,
  input  logic              mfrrWr,
  input  logic [PRIO_W-1:0] mfrrData,
  input  logic              eoiWr,
  input  logic [PRIO_W+NUM_W-1:0] eoiData,
  input  logic [PRIO_W-1:0] curCppr,
  input  logic [PRIO_W-1:0] curPend,
  input  logic [PRIO_W-1:0] curMfrr,
  input  logic              busy,
  input  logic              owned,
  output pres_ctrl_t        ctl,
  output logic              offerBounce
);

  localparam int XIRR_W = PRIO_W + NUM_W;

  logic              opAcc, opEoi, opCppr, opMfrr, anySw;
  logic [PRIO_W-1:0] newCppr, mfrrEff, ipiLimit;
  logic [NUM_W-1:0]  eoiSrc;
  logic              ipiCheck, ipiOk, offerOk;

  assign opAcc   = acceptRd;
  assign opEoi   = eoiWr && !acceptRd;
  assign opCppr  = cpprWr && !acceptRd && !eoiWr;
  assign opMfrr  = mfrrWr && !acceptRd && !eoiWr && !cpprWr;
  assign anySw   = acceptRd || eoiWr || cpprWr || mfrrWr;
  assign eoiSrc  = eoiData[NUM_W-1:0];
  assign newCppr = opEoi ? eoiData[XIRR_W-1:NUM_W] : cpprData;
  assign mfrrEff = opMfrr ? mfrrData : curMfrr;
  assign ipiLimit = opMfrr ? curCppr : newCppr;

  // IPI may be raised when its priority beats the limit and nothing at
  // least as urgent is pending.
  assign ipiOk   = (mfrrEff < ipiLimit) && !(busy && (curPend <= mfrrEff));
  assign offerOk = (offerPrio < curCppr) && !(busy && (curPend <= offerPrio));

  always_comb begin
    ctl      = '0;
    ipiCheck = 1'b0;
    if (opAcc) begin
      ctl.accept = 1'b1;
    end else if (opEoi) begin
      ctl.cpprLoad    = 1'b1;
      ctl.cpprFromEoi = 1'b1;
      ctl.fwdEoi      = (eoiSrc != '0) && (eoiSrc != NUM_W'(IPI_NUM));
      ctl.resend      = 1'b1;
      ipiCheck        = 1'b1;
    end else if (opCppr) begin
      ctl.cpprLoad = 1'b1;
      if (newCppr < curCppr) begin
        if (busy && (newCppr <= curPend)) begin
          ctl.drop      = 1'b1;
          ctl.rejectCur = owned;
        end
      end else begin
        ctl.resend = 1'b1;
        ipiCheck   = 1'b1;
      end
    end else if (opMfrr) begin
      ctl.mfrrLoad = 1'b1;
      ipiCheck     = 1'b1;
    end else if (offerValid && offerOk) begin
      ctl.takeOffer = 1'b1;
      ctl.rejectCur = busy && owned;
    end
    if (ipiCheck && ipiOk) begin
      ctl.takeIpi   = 1'b1;
      ctl.rejectCur = busy && owned;
    end
  end

  assign offerBounce = offerValid && !ctl.takeOffer;

  // R3
  offer_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && (offerPrio >= curCppr)) |-> offerBounce);

  // R10
  offer_sw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && anySw) |-> offerBounce);

  // R8
  one_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.accept, ctl.drop, ctl.takeIpi, ctl.takeOffer}));

endmodule

// File: rtl/irq_presenter_dp.sv
module irq_presenter_dp
  import irq_presenter_pkg::*;
#(
  parameter int NUM_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pres_ctrl_t        ctl,
  input  logic [NUM_W-1:0]  offerNum,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic [PRIO_W-1:0] cpprData,
  input  logic [PRIO_W-1:0] mfrrData,
  input  logic [PRIO_W+NUM_W-1:0] eoiData,
  output logic [PRIO_W-1:0] curCppr,
  output logic [PRIO_W-1:0] curPend,
  output logic [PRIO_W-1:0] curMfrr,
  output logic              busy,
  output logic              owned,
  output logic [PRIO_W+NUM_W-1:0] stateWord,
  output logic              irqOut,
  output logic              rejectValid,
  output logic [NUM_W-1:0]  rejectNum,
  output logic              resendReq,
  output logic              eoiValid,
  output logic [NUM_W-1:0]  eoiNum
);

  localparam int XIRR_W = PRIO_W + NUM_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic [NUM_W-1:0] xisr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCppr     <= '0;
      xisr        <= '0;
      curPend     <= PRIO_NONE;
      curMfrr     <= PRIO_NONE;
      owned       <= 1'b0;
      irqOut      <= 1'b0;
      rejectValid <= 1'b0;
      rejectNum   <= '0;
      resendReq   <= 1'b0;
      eoiValid    <= 1'b0;
      eoiNum      <= '0;
    end else begin
      rejectValid <= ctl.rejectCur;
      rejectNum   <= xisr;
      resendReq   <= ctl.resend;
      eoiValid    <= ctl.fwdEoi;
      eoiNum      <= eoiData[NUM_W-1:0];
      if (ctl.mfrrLoad) curMfrr <= mfrrData;
      if (ctl.accept) begin
        curCppr <= curPend;
        xisr    <= '0;
        curPend <= PRIO_NONE;
        owned   <= 1'b0;
        irqOut  <= 1'b0;
      end else begin
        if (ctl.cpprLoad)
          curCppr <= ctl.cpprFromEoi ? eoiData[XIRR_W-1:NUM_W] : cpprData;
        if (ctl.drop) begin
          xisr    <= '0;
          curPend <= PRIO_NONE;
          owned   <= 1'b0;
          irqOut  <= 1'b0;
        end else if (ctl.takeIpi) begin
          xisr    <= NUM_W'(IPI_NUM);
          curPend <= ctl.mfrrLoad ? mfrrData : curMfrr;
          owned   <= 1'b0;
          irqOut  <= 1'b1;
        end else if (ctl.takeOffer) begin
          xisr    <= offerNum;
          curPend <= offerPrio;
          owned   <= 1'b1;
          irqOut  <= 1'b1;
        end
      end
    end
  end

  assign busy      = (xisr != '0);
  assign stateWord = {curCppr, xisr};

  // R2
  line_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (xisr != '0));

  // R5
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> (!irqOut && (xisr == '0) && (curPend == PRIO_NONE)));

  // R11
  reject_num_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectValid |-> (rejectNum != '0));

  // R9
  eoi_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid |-> ((eoiNum != '0) && (eoiNum != NUM_W'(IPI_NUM))));

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int NUM_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    offerValid,
  input  logic [NUM_W-1:0]        offerNum,
  input  logic [PRIO_W-1:0]       offerPrio,
  output logic                    offerBounce,
  input  logic                    acceptRd,
  output logic [PRIO_W+NUM_W-1:0] stateWord,
  input  logic                    cpprWr,
  input  logic [PRIO_W-1:0]       cpprData,
  input  logic                    mfrrWr,
  input  logic [PRIO_W-1:0]       mfrrData,
  input  logic                    eoiWr,
  input  logic [PRIO_W+NUM_W-1:0] eoiData,
  output logic                    irqOut,
  output logic                    rejectValid,
  output logic [NUM_W-1:0]        rejectNum,
  output logic                    resendReq,
  output logic                    eoiValid,
  output logic [NUM_W-1:0]        eoiNum
);

  pres_ctrl_t        ctl;
  logic [PRIO_W-1:0] curCppr, curPend, curMfrr;
  logic              busy, owned;

  irq_presenter_ctrl #(.NUM_W(NUM_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .offerValid(offerValid), .offerPrio(offerPrio),
    .acceptRd(acceptRd), .cpprWr(cpprWr), .cpprData(cpprData),
    .mfrrWr(mfrrWr), .mfrrData(mfrrData), .eoiWr(eoiWr), .eoiData(eoiData),
    .curCppr(curCppr), .curPend(curPend), .curMfrr(curMfrr),
    .busy(busy), .owned(owned), .ctl(ctl), .offerBounce(offerBounce)
  );

  irq_presenter_dp #(.NUM_W(NUM_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .offerNum(offerNum), .offerPrio(offerPrio),
    .cpprData(cpprData), .mfrrData(mfrrData), .eoiData(eoiData),
    .curCppr(curCppr), .curPend(curPend), .curMfrr(curMfrr),
    .busy(busy), .owned(owned), .stateWord(stateWord), .irqOut(irqOut),
    .rejectValid(rejectValid), .rejectNum(rejectNum), .resendReq(resendReq),
    .eoiValid(eoiValid), .eoiNum(eoiNum)
  );

endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        offerValid = 1'b0;
  logic [23:0] offerNum = '0;
  logic [7:0]  offerPrio = '0;
  logic        offerBounce;
  logic        acceptRd = 1'b0;
  logic [31:0] stateWord;
  logic        cpprWr = 1'b0;
  logic [7:0]  cpprData = '0;
  logic        mfrrWr = 1'b0;
  logic [7:0]  mfrrData = '0;
  logic        eoiWr = 1'b0;
  logic [31:0] eoiData = '0;
  logic        irqOut, rejectValid, resendReq, eoiValid;
  logic [23:0] rejectNum, eoiNum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [7:0]  mCppr = 8'h00, mPend = 8'hFF, mMfrr = 8'hFF;
  logic [23:0] mXisr = '0;
  bit          mOwned = 1'b0;

  always #5 clk = ~clk;

  irq_presenter i_irq_presenter (
    .clk(clk), .rstN(rstN), .offerValid(offerValid), .offerNum(offerNum),
    .offerPrio(offerPrio), .offerBounce(offerBounce), .acceptRd(acceptRd),
    .stateWord(stateWord), .cpprWr(cpprWr), .cpprData(cpprData),
    .mfrrWr(mfrrWr), .mfrrData(mfrrData), .eoiWr(eoiWr), .eoiData(eoiData),
    .irqOut(irqOut), .rejectValid(rejectValid), .rejectNum(rejectNum),
    .resendReq(resendReq), .eoiValid(eoiValid), .eoiNum(eoiNum)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive, check same-cycle answers, then registered outputs.
  task automatic step(input bit a, input bit e, input bit c, input bit m,
                      input bit o, input logic [31:0] ed, input logic [7:0] cd,
                      input logic [7:0] md, input logic [23:0] on,
                      input logic [7:0] op);
    bit expBounce, expRej, expEoi, expRes, ipiTry;
    logic [23:0] expRejNum;
    logic [7:0] lim, mEff;
    @(negedge clk);
    acceptRd = a; eoiWr = e; cpprWr = c; mfrrWr = m; offerValid = o;
    eoiData = ed; cpprData = cd; mfrrData = md; offerNum = on; offerPrio = op;
    #1;
    chk(stateWord == {mCppr, mXisr}, "R2 R5 state word before edge",
        stateWord, {mCppr, mXisr});
    expBounce = o; expRej = 0; expEoi = 0; expRes = 0; ipiTry = 0;
    expRejNum = mXisr; lim = mCppr; mEff = mMfrr;
    if (a) begin
      mCppr = mPend; mXisr = '0; mPend = 8'hFF; mOwned = 0;
    end else if (e) begin
      mCppr = ed[31:24];
      expEoi = (ed[23:0] != 0) && (ed[23:0] != 24'd2);
      expRes = 1; ipiTry = 1; lim = mCppr;
    end else if (c) begin
      if (cd < mCppr) begin
        if (mXisr != 0 && cd <= mPend) begin
          expRej = mOwned; mXisr = '0; mPend = 8'hFF; mOwned = 0;
        end
      end else begin
        expRes = 1; ipiTry = 1; lim = cd;
      end
      mCppr = cd;
    end else if (m) begin
      mMfrr = md; mEff = md; ipiTry = 1; lim = mCppr;
    end else if (o) begin
      if (!(op >= mCppr || (mXisr != 0 && mPend <= op))) begin
        expBounce = 0; expRej = (mXisr != 0) && mOwned;
        mXisr = on; mPend = op; mOwned = 1;
      end
    end
    if (ipiTry && mEff < lim && !(mXisr != 0 && mPend <= mEff)) begin
      expRej = (mXisr != 0) && mOwned;
      mXisr = 24'd2; mPend = mEff; mOwned = 0;
    end
    chk(offerBounce == expBounce, "R3 R10 offer bounce", 32'(offerBounce),
        32'(expBounce));
    @(posedge clk);
    #1;
    acceptRd = 0; eoiWr = 0; cpprWr = 0; mfrrWr = 0; offerValid = 0;
    chk(stateWord == {mCppr, mXisr}, "R2 R4 R5 R6 R8 R9 state after edge",
        stateWord, {mCppr, mXisr});
    chk(irqOut == (mXisr != 0), "R2 R4 R8 line", 32'(irqOut), 32'(mXisr != 0));
    chk(rejectValid == expRej && (!expRej || rejectNum == expRejNum),
        "R4 R6 R8 R11 reject", {rejectValid, 7'd0, rejectNum},
        {expRej, 7'd0, expRejNum});
    chk(eoiValid == expEoi && (!expEoi || eoiNum == ed[23:0]), "R9 eoi forward",
        {eoiValid, 7'd0, eoiNum}, {expEoi, 7'd0, ed[23:0]});
    chk(resendReq == expRes, "R7 R9 R11 resend", 32'(resendReq), 32'(expRes));
  endtask

  function automatic logic [7:0] pickPrio();
    int r = $urandom_range(0, 9);
    return (r == 9) ? 8'hFF : 8'(r);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(irqOut == 0, "R1 line low", 32'(irqOut), 0);
    chk(stateWord == 0, "R1 state word", stateWord, 0);
    chk(!rejectValid && !resendReq && !eoiValid, "R1 no pulses",
        {rejectValid, resendReq, eoiValid}, 0);
    // R1: accept right after reset yields pending priority 0xFF as CPPR
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(stateWord == 32'hFF00_0000, "R1 pending priority FF", stateWord,
        32'hFF00_0000);
    // R1: IPI priority FF raises nothing even with CPPR FF
    step(0, 0, 1, 0, 0, 0, 8'hFF, 0, 0, 0);                 // R7 resend
    step(0, 0, 0, 0, 1, 0, 0, 0, 24'h100, 8'd5);            // take
    step(0, 0, 0, 0, 1, 0, 0, 0, 24'h101, 8'd5);            // R3 equal pending
    step(0, 0, 0, 0, 1, 0, 0, 0, 24'h102, 8'd3);            // R4 displace
    step(0, 0, 0, 0, 1, 0, 0, 0, 24'h103, 8'hFF);           // R3 >= CPPR
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);                     // R5 accept
    step(0, 1, 0, 0, 0, 32'hFF00_0102, 0, 0, 0, 0);         // R9 eoi
    step(0, 0, 0, 1, 0, 0, 0, 8'd4, 0, 0);                  // R8 IPI
    chk(stateWord[23:0] == 24'd2, "R8 IPI number", stateWord, 32'hFF00_0002);
    step(0, 0, 0, 0, 1, 0, 0, 0, 24'h200, 8'd2);            // R4 IPI displaced
    step(0, 0, 1, 0, 0, 0, 8'd1, 0, 0, 0);                  // R6 drop
    step(0, 1, 0, 0, 0, 32'hFF00_0002, 0, 0, 0, 0);         // R9 IPI eoi
    step(0, 0, 1, 0, 1, 0, 8'hFF, 0, 24'h300, 8'd0);        // R10
    step(1, 1, 1, 1, 1, 32'h0500_0400, 8'd3, 8'd2, 24'h301, 8'd0); // R10
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 11);
      int k = $urandom_range(0, 3);
      logic [23:0] en = (k == 0) ? 24'd0 : (k == 1) ? 24'd2 :
                        24'(16 + $urandom_range(0, 60));
      step(r == 0, r == 1, r == 2 || r == 11, r == 3 || r == 11,
           r >= 4 || r == 11 || ($urandom_range(0, 7) == 0),
           {pickPrio(), en}, pickPrio(), pickPrio(),
           24'(16 + $urandom_range(0, 60)), pickPrio());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule